// File: doc/BRIEF.md
# Multi-mode accumulator core

This block is a small multi-cycle processor core built around one accumulator. It fetches instructions of varying length from a single word-addressed memory through a synchronous read port. Instructions and data share that memory, and no word carries a type tag. A word is read as an opcode, an address, a pointer or a value only because of where it falls in the fetch sequence.

The core executes an add in four addressing modes: immediate, direct, memory-indirect and indexed. It also executes an absolute branch and a PC-relative branch. Each addressing mode costs a different number of memory reads. The indirect and indexed forms need two dereferences before the value to add is known.

The core runs a fixed state sequence: opcode fetch, operand fetch, any pointer or index dereferences, then the accumulator or PC update. Opcodes outside the supported set stop the core until it is reset. Memory is read-only from the core's side, and its contents are preloaded by the environment.

Top module: `accum_core`

## Requirements
- R1: While reset is asserted (rst_n low), pc and acc are zero and halted is low. The first opcode fetch after reset uses address 0.
- R2: Opcode 41 (add immediate) adds the word following the opcode to acc and advances pc by 2. Both updates take effect on the third rising clock edge after the fetch of the opcode begins, and no data read is made.
- R3: Opcode 40 (add direct) treats the next word as an address A and adds memory[A] to acc. It advances pc by 2, and the update takes effect on the fourth edge.
- R4: Opcode 42 (add indirect) treats the next word as a pointer location P and adds memory[memory[P]] to acc. It advances pc by 2, and the update takes effect on the fifth edge.
- R5: Opcode 43 (add indexed) reads a base B and an index location X from the two words after the opcode, in that order. It adds memory[(B + memory[X]) mod 256] to acc and advances pc by 3. The update takes effect on the sixth edge.
- R6: Opcode 70 (absolute branch) loads the low 8 bits of the next word into pc, leaves acc unchanged, and takes effect on the third edge.
- R7: Opcode 167 (relative branch) sets pc to (address of the opcode + next word) mod 256, with the word read as two's complement. It leaves acc unchanged and takes effect on the third edge.
- R8: Any memory word may serve as opcode, address or data according to its position alone. Address sums wrap modulo 256, and accumulator sums wrap modulo 65536.
- R9: Any other opcode value raises halted on the second edge after its fetch begins. After that, halted stays high and pc and acc hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Read address presented to memory this cycle |
| mem_rdata | input | 16 | Word at the address presented on the previous cycle |
| acc | output | 16 | Accumulator |
| pc | output | 8 | Program counter (address of the next opcode) |
| halted | output | 1 | Sticky stop flag set by an undefined opcode |

## Verification
The embedded assertions cover the following on every cycle:
- halted stays high once set, and pc and acc are frozen while it is high.
- The opcode-fetch and decode steps never change pc or acc.
- Branches leave acc untouched.
- A completing immediate add advances pc by exactly 2, and a completing indexed add advances it by exactly 3.

Other behaviours only show up in the bench scenarios, where a behavioural model checks pc, acc and halted on every clock:
- The values actually added for each addressing mode.
- The per-mode cycle counts.
- Relative branch targets, including backward offsets that wrap below address 0.
- An indexed add whose effective address wraps around onto an opcode word.

// File: rtl/accum_core.sv
module accum_core #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc,
  output logic          halted
);

  localparam logic [DW-1:0] OP_DIR = DW'(40);
  localparam logic [DW-1:0] OP_IMM = DW'(41);
  localparam logic [DW-1:0] OP_IND = DW'(42);
  localparam logic [DW-1:0] OP_IDX = DW'(43);
  localparam logic [DW-1:0] OP_JMP = DW'(70);
  localparam logic [DW-1:0] OP_REL = DW'(167);

  typedef enum logic [2:0] {
    S_FETCH, S_DEC, S_OPND, S_PTR, S_IDX, S_XVAL, S_DATA, S_HALT
  } st_t;

  st_t           st;
  logic [DW-1:0] op;
  logic [AW-1:0] base;
  logic          legal;

  assign legal  = (mem_rdata == OP_DIR) || (mem_rdata == OP_IMM) ||
                  (mem_rdata == OP_IND) || (mem_rdata == OP_IDX) ||
                  (mem_rdata == OP_JMP) || (mem_rdata == OP_REL);
  assign halted = (st == S_HALT);

  always_comb begin
    case (st)
      S_FETCH: mem_addr = pc;
      S_DEC:   mem_addr = pc + AW'(1);
      S_OPND:  mem_addr = (op == OP_IDX) ? pc + AW'(2) : mem_rdata[AW-1:0];
      S_PTR:   mem_addr = mem_rdata[AW-1:0];
      S_IDX:   mem_addr = mem_rdata[AW-1:0];
      S_XVAL:  mem_addr = base + mem_rdata[AW-1:0];
      default: mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_FETCH;
      op   <= '0;
      base <= '0;
      acc  <= '0;
      pc   <= '0;
    end else begin
      case (st)
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          op <= mem_rdata;
          st <= legal ? S_OPND : S_HALT;
        end
        S_OPND: begin
          case (op)
            OP_IMM: begin
              acc <= acc + mem_rdata;
              pc  <= pc + AW'(2);
              st  <= S_FETCH;
            end
            OP_JMP: begin
              pc <= mem_rdata[AW-1:0];
              st <= S_FETCH;
            end
            OP_REL: begin
              pc <= pc + mem_rdata[AW-1:0];
              st <= S_FETCH;
            end
            OP_DIR: st <= S_DATA;
            OP_IND: st <= S_PTR;
            OP_IDX: begin
              base <= mem_rdata[AW-1:0];
              st   <= S_IDX;
            end
            default: st <= S_HALT;
          endcase
        end
        S_PTR:  st <= S_DATA;
        S_IDX:  st <= S_XVAL;
        S_XVAL: st <= S_DATA;
        S_DATA: begin
          acc <= acc + mem_rdata;
          pc  <= pc + ((op == OP_IDX) ? AW'(3) : AW'(2));
          st  <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(acc)));

  assert_fetch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH || st == S_DEC) |=> ($stable(pc) && $stable(acc)));

  assert_branch_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPND && (op == OP_JMP || op == OP_REL)) |=> $stable(acc));

  assert_imm_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPND && op == OP_IMM) |=> (pc == $past(pc) + AW'(2)));

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && op == OP_IDX) |=> (pc == $past(pc) + AW'(3)));

endmodule

// File: tb/accum_core_tb.sv
module accum_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] acc;
  logic [7:0]  pc;
  logic        halted;
  logic [15:0] mem [0:255];

  int checks = 0;
  int failures = 0;
  int m_pc = 0;
  int m_acc = 0;
  bit m_halt = 0;

  always #5 clk = ~clk;

  accum_core u_dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
                    .mem_rdata(mem_rdata), .acc(acc), .pc(pc), .halted(halted));

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp(input string req);
    chk(int'(pc) == m_pc, req, "pc", int'(pc), m_pc);
    chk(int'(acc) == m_acc, req, "acc", int'(acc), m_acc);
    chk(halted == m_halt, req, "halted", int'(halted), int'(m_halt));
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'd0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_pc = 0; m_acc = 0; m_halt = 0;
    repeat (2) @(negedge clk);
    cmp("R1");
  endtask

  task automatic run_prog(input int max_instr);
    @(negedge clk);
    rst_n = 1;
    for (int n = 0; n < max_instr && !m_halt; n++) begin
      int op, w1, w2, cost, npc, nacc;
      bit nh;
      string req;
      op = int'(mem[m_pc]);
      w1 = int'(mem[(m_pc + 1) & 255]);
      w2 = int'(mem[(m_pc + 2) & 255]);
      npc = m_pc; nacc = m_acc; nh = 0;
      case (op)
        41: begin cost = 3; req = "R2"; nacc = (m_acc + w1) & 16'hFFFF; npc = (m_pc + 2) & 255; end
        40: begin cost = 4; req = "R3"; nacc = (m_acc + int'(mem[w1 & 255])) & 16'hFFFF; npc = (m_pc + 2) & 255; end
        42: begin cost = 5; req = "R4";
              nacc = (m_acc + int'(mem[int'(mem[w1 & 255]) & 255])) & 16'hFFFF; npc = (m_pc + 2) & 255; end
        43: begin cost = 6; req = "R5";
              nacc = (m_acc + int'(mem[(w1 + int'(mem[w2 & 255])) & 255])) & 16'hFFFF; npc = (m_pc + 3) & 255; end
        70: begin cost = 3; req = "R6"; npc = w1 & 255; end
        167: begin cost = 3; req = "R7"; npc = (m_pc + w1) & 255; end
        default: begin cost = 2; req = "R9"; nh = 1; end
      endcase
      for (int k = 1; k <= cost; k++) begin
        @(negedge clk);
        if (k == cost) begin m_pc = npc; m_acc = nacc; m_halt = nh; end
        cmp(req);
      end
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmp("R9");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mem();
    mem[0] = 41;  mem[1] = 5;
    mem[2] = 40;  mem[3] = 100;
    mem[4] = 42;  mem[5] = 101;
    mem[6] = 43;  mem[7] = 110;  mem[8] = 103;
    mem[9] = 70;  mem[10] = 20;
    mem[20] = 167; mem[21] = 16'hFFFC;
    mem[16] = 41; mem[17] = 16'hFFFF;
    mem[18] = 167; mem[19] = 30;
    mem[48] = 40; mem[49] = 250;
    mem[50] = 43; mem[51] = 250; mem[52] = 104;
    mem[53] = 0;
    mem[100] = 7; mem[101] = 102; mem[102] = 3; mem[103] = 4;
    mem[104] = 10; mem[114] = 20; mem[250] = 1;
    do_reset();
    run_prog(20);
    // R8: indexed sum 250+10 wraps to address 4, which holds the opcode word 42
    chk(acc == 16'd77, "R8", "final acc", int'(acc), 77);
    chk(pc == 8'd53, "R9", "final pc", int'(pc), 53);
    chk(halted == 1'b1, "R9", "halted", int'(halted), 1);

    rst_n = 0;
    clear_mem();
    mem[0] = 167; mem[1] = 16'hFFFE;
    mem[254] = 70; mem[255] = 2;
    mem[2] = 41;  mem[3] = 9;
    mem[4] = 16'h00FF;
    do_reset();
    run_prog(10);
    // R7: backward relative branch from 0 wraps to 254
    chk(pc == 8'd4, "R7", "final pc", int'(pc), 4);
    chk(acc == 16'd9, "R2", "final acc", int'(acc), 9);
    do_reset();
    chk(acc == 16'd0 && pc == 8'd0, "R1", "cleared after reset", int'(acc), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule